// File: doc/BRIEF.md
# Boot and Code-Protection Option Controller

This block holds the option byte of a small microcontroller and enforces what that byte says. While the power-on reset is held low, the byte is loaded from the non-volatile store on every clock. When power-on reset is released, the byte is frozen for the rest of the run, and nothing the running program does can change it.

The frozen byte drives four things:
- A lock bit, which blocks every external read of the flash contents and of the setting registers.
- A table-read restriction bit, which keeps table reads issued from external code away from internal program memory.
- Two reboot enables. These select the loader flash region as the boot source when the strap pins are low while the chip reset is high.
- The oscillator range, which is passed out as a static mode output.

Denied reads return all ones and raise a one-cycle violation pulse. Read results and the violation flag are registered, so they appear one clock after the request. The boot-source output is updated on every clock edge at which the chip reset is high. Once the chip reset is low, the boot source holds.

Top module: `cfg_option_ctrl`

## Requirements
- R1: While porN is low, the option byte is loaded from cfgIn on each clock. After porN goes high, later changes on cfgIn have no effect. This is visible through the setting-register read path and through xtalHi.
- R2: When option bit 0 is 0, a request on extRdReq gives extRdData = all ones one cycle later, with accessViol = 1 in that cycle. This holds for both extRdSel values.
- R3: When option bit 0 is 1, extRdReq returns the following one cycle later, with no violation. With extRdSel = 0 it returns arrData. With extRdSel = 1 it returns the held option byte, zero-extended.
- R4: When option bit 1 is 0, a table read with tblFromExt = 1 and tblTgtInt = 1 returns all ones on tblData one cycle later, with accessViol = 1.
- R5: A table read with tblFromExt = 0 returns the following one cycle later with no violation, whatever the value of bit 1. With tblTgtInt = 1 it returns tblIntData. With tblTgtInt = 0 it returns tblExtData.
- R6: When option bit 1 is 1, no table read is ever denied.
- R7: When option bit 4 is 0, bootLoader (1 = loader flash, 0 = user flash) becomes 1 after a clock edge with rstHi = 1 and both pinPair bits low.
- R8: When option bit 5 is 0, bootLoader becomes 1 after a clock edge with rstHi = 1 and pinSolo low.
- R9: bootLoader holds its value on every edge with rstHi = 0. With bits 4 and 5 both 1, it is 0 whatever the pins are. If both enables are active, meeting either pin condition selects the loader.
- R10: xtalHi equals option bit 7. Reserved bits 3 and 6 are read back unchanged through the setting-register read path.
- R11: accessViol is 1 only in the cycle after a denied request, so a cycle with no request leaves it 0. When an external read and a table read are denied in the same cycle, both data outputs return all ones and a single flag cycle is raised.
- R12: While porN is low, extRdData, tblData, accessViol and bootLoader are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low; option byte is loaded while low |
| cfgIn | input | 8 | Option byte from the non-volatile store |
| rstHi | input | 1 | Chip reset pin, active high; strap pins are sampled while high |
| pinPair | input | 2 | Dedicated strap pair for the first reboot enable |
| pinSolo | input | 1 | Alternate strap pin for the second reboot enable |
| extRdReq | input | 1 | External read request |
| extRdSel | input | 1 | 0 = flash contents, 1 = setting registers |
| arrData | input | 8 | Flash array data for the external read |
| extRdData | output | 8 | Registered external read result |
| tblReq | input | 1 | Table-read request |
| tblFromExt | input | 1 | Executing instruction lies in external program memory |
| tblTgtInt | input | 1 | Table-read target lies in internal program memory |
| tblIntData | input | 8 | Internal memory data for the table read |
| tblExtData | input | 8 | External memory data for the table read |
| tblData | output | 8 | Registered table-read result |
| accessViol | output | 1 | One-cycle pulse after any denied read |
| bootLoader | output | 1 | Boot source: 1 = loader flash, 0 = user flash |
| xtalHi | output | 1 | Oscillator range from the option byte |

## Verification
A locked external read and a denied table read can fall in the same cycle. Both feed the single violation flag, while each drives its own data output. The bench provokes this with the lock and restriction bits both cleared and the two requests asserted together. It also produces that overlap again in a stretch of random traffic. The behavioural model then expects both data outputs at all ones and exactly one flag cycle. A boot-strap sample can also land on the same edge as a denied read; the model checks that the two functions do not disturb each other.

// File: rtl/cfg_option_pkg.sv
package cfg_option_pkg;
  localparam int CFG_W    = 8;
  localparam int LOCK_BIT = 0;
  localparam int TBL_BIT  = 1;
  localparam int PAIR_BIT = 4;
  localparam int SOLO_BIT = 5;
  localparam int XTAL_BIT = 7;

  typedef struct packed {
    logic capture;
    logic extDeny;
    logic extServe;
    logic tblDeny;
    logic tblServe;
  } optStrobe_t;
endpackage

// File: rtl/cfg_option_ctl.sv
module cfg_option_ctl
  import cfg_option_pkg::*;
#(
  parameter int PAIR_N = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstHi,
  input  logic [CFG_W-1:0]  cfgHeld,
  input  logic [PAIR_N-1:0] pinPair,
  input  logic              pinSolo,
  input  logic              extRdReq,
  input  logic              tblReq,
  input  logic              tblFromExt,
  input  logic              tblTgtInt,
  output optStrobe_t        stb,
  output logic              bootLoader
);
  logic pairLow;
  logic wantLoader;

  // Every strap of the pair must be low; built per pin.
  logic [PAIR_N-1:0] pinLow;
  for (genvar i = 0; i < PAIR_N; i++) begin : g_pair
    assign pinLow[i] = ~pinPair[i];
  end
  assign pairLow = &pinLow;

  assign wantLoader = (~cfgHeld[PAIR_BIT] & pairLow) |
                      (~cfgHeld[SOLO_BIT] & ~pinSolo);

  always_comb begin
    stb          = '0;
    stb.capture  = ~porN;
    stb.extDeny  = porN & extRdReq & ~cfgHeld[LOCK_BIT];
    stb.extServe = porN & extRdReq &  cfgHeld[LOCK_BIT];
    stb.tblDeny  = porN & tblReq & tblFromExt & tblTgtInt & ~cfgHeld[TBL_BIT];
    stb.tblServe = porN & tblReq & ~stb.tblDeny;
  end

  always_ff @(posedge clk) begin
    if (!porN)      bootLoader <= 1'b0;
    else if (rstHi) bootLoader <= wantLoader;
  end
endmodule

// File: rtl/cfg_option_dp.sv
module cfg_option_dp
  import cfg_option_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             porN,
  input  optStrobe_t       stb,
  input  logic [CFG_W-1:0] cfgIn,
  input  logic             extRdSel,
  input  logic [DW-1:0]    arrData,
  input  logic             tblTgtInt,
  input  logic [DW-1:0]    tblIntData,
  input  logic [DW-1:0]    tblExtData,
  output logic [CFG_W-1:0] cfgHeld,
  output logic [DW-1:0]    extRdData,
  output logic [DW-1:0]    tblData,
  output logic             accessViol
);
  localparam logic [DW-1:0] DENY_VAL = '1;

  logic [DW-1:0] cfgWide;
  assign cfgWide = DW'(cfgHeld);

  always_ff @(posedge clk) begin
    if (stb.capture) cfgHeld <= cfgIn;
  end

  always_ff @(posedge clk) begin
    if (!porN) begin
      extRdData  <= '0;
      tblData    <= '0;
      accessViol <= 1'b0;
    end else begin
      accessViol <= stb.extDeny | stb.tblDeny;
      if (stb.extDeny)       extRdData <= DENY_VAL;
      else if (stb.extServe) extRdData <= extRdSel ? cfgWide : arrData;
      if (stb.tblDeny)       tblData <= DENY_VAL;
      else if (stb.tblServe) tblData <= tblTgtInt ? tblIntData : tblExtData;
    end
  end
endmodule

// File: rtl/cfg_option_ctrl.sv
module cfg_option_ctrl
  import cfg_option_pkg::*;
#(
  parameter int DW     = 8,
  parameter int PAIR_N = 2
) (
  input  logic              clk,
  input  logic              porN,
  input  logic [CFG_W-1:0]  cfgIn,
  input  logic              rstHi,
  input  logic [PAIR_N-1:0] pinPair,
  input  logic              pinSolo,
  input  logic              extRdReq,
  input  logic              extRdSel,
  input  logic [DW-1:0]     arrData,
  output logic [DW-1:0]     extRdData,
  input  logic              tblReq,
  input  logic              tblFromExt,
  input  logic              tblTgtInt,
  input  logic [DW-1:0]     tblIntData,
  input  logic [DW-1:0]     tblExtData,
  output logic [DW-1:0]     tblData,
  output logic              accessViol,
  output logic              bootLoader,
  output logic              xtalHi
);
  optStrobe_t       stb;
  logic [CFG_W-1:0] cfgHeld;

  cfg_option_ctl #(.PAIR_N(PAIR_N)) u_ctl (
    .clk(clk), .porN(porN), .rstHi(rstHi), .cfgHeld(cfgHeld),
    .pinPair(pinPair), .pinSolo(pinSolo), .extRdReq(extRdReq),
    .tblReq(tblReq), .tblFromExt(tblFromExt), .tblTgtInt(tblTgtInt),
    .stb(stb), .bootLoader(bootLoader)
  );

  cfg_option_dp #(.DW(DW)) u_dp (
    .clk(clk), .porN(porN), .stb(stb), .cfgIn(cfgIn),
    .extRdSel(extRdSel), .arrData(arrData), .tblTgtInt(tblTgtInt),
    .tblIntData(tblIntData), .tblExtData(tblExtData),
    .cfgHeld(cfgHeld), .extRdData(extRdData), .tblData(tblData),
    .accessViol(accessViol)
  );

  assign xtalHi = cfgHeld[XTAL_BIT];
endmodule

// File: rtl/cfg_option_chk.sv
module cfg_option_chk
  import cfg_option_pkg::*;
#(
  parameter int DW = 8
) (
  input logic             clk,
  input logic             porN,
  input logic             rstHi,
  input logic [CFG_W-1:0] cfgHeld,
  input logic             extRdReq,
  input logic             tblReq,
  input logic             tblFromExt,
  input logic             tblTgtInt,
  input logic [DW-1:0]    tblIntData,
  input logic [DW-1:0]    tblExtData,
  input logic [DW-1:0]    extRdData,
  input logic [DW-1:0]    tblData,
  input logic             accessViol,
  input logic             bootLoader
);
  p_frozen_r1: assert property (@(posedge clk) disable iff (!porN)
    porN |=> $stable(cfgHeld));

  p_lock_r2: assert property (@(posedge clk) disable iff (!porN)
    (extRdReq && !cfgHeld[LOCK_BIT]) |=> (extRdData == '1 && accessViol));

  p_tbl_deny_r4: assert property (@(posedge clk) disable iff (!porN)
    (tblReq && tblFromExt && tblTgtInt && !cfgHeld[TBL_BIT])
      |=> (tblData == '1 && accessViol));

  p_int_code_r5: assert property (@(posedge clk) disable iff (!porN)
    (tblReq && !tblFromExt)
      |=> tblData == $past(tblTgtInt ? tblIntData : tblExtData));

  p_boot_hold_r9: assert property (@(posedge clk) disable iff (!porN)
    !rstHi |=> $stable(bootLoader));

  p_quiet_r11: assert property (@(posedge clk) disable iff (!porN)
    (!extRdReq && !tblReq) |=> !accessViol);
endmodule

bind cfg_option_ctrl cfg_option_chk #(.DW(DW)) u_chk (
  .clk(clk), .porN(porN), .rstHi(rstHi), .cfgHeld(cfgHeld),
  .extRdReq(extRdReq), .tblReq(tblReq), .tblFromExt(tblFromExt),
  .tblTgtInt(tblTgtInt), .tblIntData(tblIntData), .tblExtData(tblExtData),
  .extRdData(extRdData), .tblData(tblData), .accessViol(accessViol),
  .bootLoader(bootLoader)
);

// File: tb/sim_cfg_option_ctrl.sv
module sim_cfg_option_ctrl;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       porN = 1'b0;
  logic [7:0] cfgIn = '0;
  logic       rstHi = 1'b0;
  logic [1:0] pinPair = 2'b11;
  logic       pinSolo = 1'b1;
  logic       extRdReq = 1'b0, extRdSel = 1'b0;
  logic [7:0] arrData = '0;
  logic       tblReq = 1'b0, tblFromExt = 1'b0, tblTgtInt = 1'b0;
  logic [7:0] tblIntData = '0, tblExtData = '0;
  logic [7:0] extRdData, tblData;
  logic       accessViol, bootLoader, xtalHi;

  int checks = 0;
  int fails = 0;

  // behavioural reference state
  logic [7:0] mCfg = '0;
  logic [7:0] mExt = '0, mTbl = '0;
  logic       mViol = 1'b0, mBoot = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  cfg_option_ctrl u0 (
    .clk(clk), .porN(porN), .cfgIn(cfgIn), .rstHi(rstHi),
    .pinPair(pinPair), .pinSolo(pinSolo), .extRdReq(extRdReq),
    .extRdSel(extRdSel), .arrData(arrData), .extRdData(extRdData),
    .tblReq(tblReq), .tblFromExt(tblFromExt), .tblTgtInt(tblTgtInt),
    .tblIntData(tblIntData), .tblExtData(tblExtData), .tblData(tblData),
    .accessViol(accessViol), .bootLoader(bootLoader), .xtalHi(xtalHi)
  );

  function automatic void step();
    logic v;
    if (!porN) begin
      mCfg = cfgIn; mExt = '0; mTbl = '0; mViol = 1'b0; mBoot = 1'b0;
    end else begin
      v = 1'b0;
      if (extRdReq) begin
        if (mCfg[0] == 1'b0) begin mExt = 8'hFF; v = 1'b1; end
        else mExt = extRdSel ? mCfg : arrData;
      end
      if (tblReq) begin
        if (tblFromExt && tblTgtInt && mCfg[1] == 1'b0) begin
          mTbl = 8'hFF; v = 1'b1;
        end else mTbl = tblTgtInt ? tblIntData : tblExtData;
      end
      mViol = v;
      if (rstHi)
        mBoot = (!mCfg[4] && pinPair == 2'b00) || (!mCfg[5] && !pinSolo);
    end
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    step();
    @(negedge clk);
    chk(tag, "extRdData", extRdData, mExt);
    chk(tag, "tblData", tblData, mTbl);
    chk(tag, "accessViol", {7'b0, accessViol}, {7'b0, mViol});
    chk(tag, "bootLoader", {7'b0, bootLoader}, {7'b0, mBoot});
    chk(tag, "xtalHi", {7'b0, xtalHi}, {7'b0, mCfg[7]});
  endtask

  task automatic idle();
    extRdReq = 1'b0; tblReq = 1'b0;
  endtask

  task automatic powerUp(input logic [7:0] v);
    idle();
    porN = 1'b0; cfgIn = v; rstHi = 1'b0;
    tick("R12 reset state");
    tick("R12 reset state");
    porN = 1'b1;
    tick("R1 capture");
  endtask

  task automatic extRead(input string tag, input logic sel, input logic [7:0] d);
    idle(); extRdReq = 1'b1; extRdSel = sel; arrData = d;
    tick(tag);
    idle(); tick("R11 quiet after request");
  endtask

  task automatic tblRead(input string tag, input logic fromExt, input logic tgtInt);
    idle(); tblReq = 1'b1; tblFromExt = fromExt; tblTgtInt = tgtInt;
    tblIntData = 8'h3C; tblExtData = 8'hA5;
    tick(tag);
    idle(); tick("R11 quiet after request");
  endtask

  task automatic strap(input string tag, input logic [1:0] pp, input logic ps);
    idle(); pinPair = pp; pinSolo = ps; rstHi = 1'b1;
    tick(tag); tick(tag);
    rstHi = 1'b0;
    tick(tag);
    pinPair = ~pp; pinSolo = ~ps;
    tick("R9 hold after reset release");
    tick("R9 hold after reset release");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    // R1, R3, R6: unlocked, unrestricted, both reboots off
    powerUp(8'hFF);
    cfgIn = 8'h00;
    tick("R1 cfgIn ignored after release");
    extRead("R1 frozen byte readback", 1'b1, 8'h00);
    extRead("R3 flash read", 1'b0, 8'h5A);
    extRead("R3 settings read", 1'b1, 8'h11);
    tblRead("R6 ext code to internal", 1'b1, 1'b1);
    tblRead("R6 ext code to external", 1'b1, 1'b0);
    tblRead("R5 int code to internal", 1'b0, 1'b1);
    strap("R9 both enables off", 2'b00, 1'b0);

    // R2, R4, R5, R7, R11: locked, restricted, pair reboot on
    powerUp(8'h6C);
    extRead("R2 locked flash read", 1'b0, 8'h12);
    extRead("R2 locked settings read", 1'b1, 8'h12);
    tblRead("R4 ext code to internal denied", 1'b1, 1'b1);
    tblRead("R4 ext code to external allowed", 1'b1, 1'b0);
    tblRead("R5 int code to internal", 1'b0, 1'b1);
    tblRead("R5 int code to external", 1'b0, 1'b0);
    idle(); extRdReq = 1'b1; tblReq = 1'b1; tblFromExt = 1'b1; tblTgtInt = 1'b1;
    tick("R11 double denial");
    idle(); tick("R11 single flag cycle");
    strap("R7 pair low", 2'b00, 1'b1);
    strap("R7 one pair pin high", 2'b01, 1'b1);
    strap("R8 solo disabled", 2'b11, 1'b0);

    // R8, R10: solo reboot on, reserved bits readback
    powerUp(8'hD1);
    extRead("R10 reserved bits readback", 1'b1, 8'h00);
    strap("R8 solo low", 2'b11, 1'b0);
    strap("R8 pair disabled", 2'b00, 1'b1);

    // R9: both enables on, either condition
    powerUp(8'h0C);
    strap("R9 either condition pair", 2'b00, 1'b1);
    strap("R9 either condition solo", 2'b11, 1'b0);
    strap("R9 neither condition", 2'b10, 1'b1);

    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      if (n % 150 == 0) begin
        porN = 1'b0; cfgIn = 8'($urandom);
      end else begin
        porN = 1'b1; cfgIn = 8'($urandom);
      end
      rstHi = ($urandom % 5) == 0;
      pinPair = 2'($urandom); pinSolo = 1'($urandom);
      extRdReq = 1'($urandom); extRdSel = 1'($urandom); arrData = 8'($urandom);
      tblReq = 1'($urandom); tblFromExt = 1'($urandom); tblTgtInt = 1'($urandom);
      tblIntData = 8'($urandom); tblExtData = 8'($urandom);
      tick("R11 random mix");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule